// File: doc/BRIEF.md
# Virtual Channel Packet Arbiter

This block sits between a set of per-channel transmit buffers and a single link-layer transmitter. It decides which of four virtual channels sends its buffered packet next. A channel asks for service when it is enabled and its request is ready. A request is ready when the whole packet is already buffered, or when the channel's buffer region has filled up. Readiness is looked at again every time a packet finishes, so a channel whose region drains stops competing.

A single mode input picks the policy. With the mode at 0 the block rotates round-robin over the eligible channels and starts at channel 0. With the mode at 1 it serves one channel until that channel has no ready request left, and only then moves on in rotation order. Each grant names one channel and carries that channel's packet length. A one-cycle start strobe marks the first cycle of the grant. The grant stays up until the transmitter returns a packet-done pulse, and the block makes its next decision in the cycle after that pulse.

Top module: `vc_pkt_arbiter`

## Requirements
- R1: A channel whose enable bit is 0 is never granted, whatever its readiness flags say.
- R2: An enabled channel is eligible when its packet-complete flag is 1 or its region-full flag is 1, and not eligible when both are 0. Both flags are re-read at every decision.
- R3: With `seq_mode`=0 and all four channels eligible, successive grants go to channels 0, 1, 2, 3, 0 in that order after reset.
- R4: With `seq_mode`=0, each decision grants the first eligible channel found by counting upward from the channel after the last one granted, wrapping from 3 to 0. Channels that are not eligible are skipped.
- R5: With `seq_mode`=1, the channel granted last is granted again as long as it is still eligible at the decision.
- R6: With `seq_mode`=1, once the last granted channel is no longer eligible, the next grant goes to the first eligible channel in rotation order after it.
- R7: `grant` is one-hot or zero. `pkt_start` is high for exactly the first cycle of a grant. The grant and `grant_len` stay unchanged until `pkt_done` is seen.
- R8: `grant` falls to zero in the cycle after `pkt_done` is sampled high during a grant, and no new grant shows on that cycle.
- R9: A decision cycle with no eligible channel resets the rotation start to channel 0 and forgets the last served channel.
- R10: `grant_len` equals the `pkt_len` entry of the granted channel as sampled at the decision.
- R11: After reset `grant` is zero and `pkt_start` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_mode | input | 1 | 1 = sequential (drain one channel), 0 = round-robin |
| ch_en | input | 4 | Per-channel enable |
| pkt_whole | input | 4 | Per-channel flag: whole packet is buffered |
| region_full | input | 4 | Per-channel flag: buffer region is full |
| pkt_len | input | 4x16 | Per-channel packet length, channel i in slice i |
| pkt_done | input | 1 | Transmitter finished the granted packet |
| grant | output | 4 | One-hot grant to the chosen channel |
| pkt_start | output | 1 | Pulse in the first cycle of a grant |
| grant_len | output | 16 | Length of the granted channel's packet |

## Verification
The hardest case to reach from the ports is the rotation state. Neither the round-robin start point nor the remembered channel can be seen directly, so the stimulus has to build a known history before each step. It drops every channel out of eligibility for a few cycles to force the pointer back to 0 and clear the remembered channel. Then it enables a chosen subset, which lets wrap-around, skipping and the sequential hand-off be told apart from a plain priority encoder. Sequential readiness is changed between packets only, at the cycle after packet-done, which is where re-evaluation takes place.

// File: rtl/vcarb_pkg.sv
package vcarb_pkg;

    localparam int unsigned VC_COUNT = 4;
    localparam int unsigned LEN_BITS = 16;
    localparam int unsigned VC_IDX_W = (VC_COUNT > 1) ? $clog2(VC_COUNT) : 1;

    typedef logic [VC_COUNT-1:0] vc_mask_t;
    typedef logic [VC_IDX_W-1:0] vc_idx_t;
    typedef logic [LEN_BITS-1:0] pkt_len_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic    valid;
        vc_idx_t idx;
    } vc_pick_t;

    function automatic vc_idx_t wrap_inc(vc_idx_t i);
        if (int'(i) == VC_COUNT - 1)
            return '0;
        return vc_idx_t'(int'(i) + 1);
    endfunction

    function automatic vc_mask_t idx_to_mask(vc_idx_t i);
        vc_mask_t m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/vcarb_elig.sv
module vcarb_elig
    import vcarb_pkg::*;
(
    input  vc_mask_t ch_en,
    input  vc_mask_t pkt_whole,
    input  vc_mask_t region_full,
    output vc_mask_t elig
);
    for (genvar g = 0; g < VC_COUNT; g++) begin : g_ch
        assign elig[g] = ch_en[g] & (pkt_whole[g] | region_full[g]);
    end
endmodule

// File: rtl/vcarb_pick.sv
module vcarb_pick
    import vcarb_pkg::*;
(
    input  vc_mask_t elig,
    input  vc_idx_t  rr_ptr,
    input  logic     seq_mode,
    input  logic     has_last,
    input  vc_idx_t  last_ch,
    output vc_pick_t pick
);
    vc_pick_t rr_pick;

    // Scan from highest offset down so the smallest offset from rr_ptr wins.
    always_comb begin
        rr_pick = '0;
        for (int k = VC_COUNT - 1; k >= 0; k--) begin
            int s;
            s = int'(rr_ptr) + k;
            if (s >= int'(VC_COUNT))
                s = s - int'(VC_COUNT);
            if (elig[s]) begin
                rr_pick.valid = 1'b1;
                rr_pick.idx   = vc_idx_t'(s);
            end
        end
    end

    always_comb begin
        if (seq_mode && has_last && elig[last_ch]) begin
            pick.valid = 1'b1;
            pick.idx   = last_ch;
        end else begin
            pick = rr_pick;
        end
    end
endmodule

// File: rtl/vcarb_ctrl.sv
module vcarb_ctrl
    import vcarb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  vc_mask_t                elig,
    input  vc_pick_t                pick,
    input  pkt_len_t [VC_COUNT-1:0] pkt_len,
    input  logic                    pkt_done,
    output vc_idx_t                 rr_ptr,
    output logic                    has_last,
    output vc_idx_t                 last_ch,
    output vc_mask_t                grant,
    output logic                    pkt_start,
    output pkt_len_t                grant_len
);
    arb_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            rr_ptr    <= '0;
            has_last  <= 1'b0;
            last_ch   <= '0;
            grant     <= '0;
            pkt_start <= 1'b0;
            grant_len <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (pick.valid) begin
                        state_q   <= ARB_BUSY;
                        grant     <= idx_to_mask(pick.idx);
                        pkt_start <= 1'b1;
                        grant_len <= pkt_len[pick.idx];
                        last_ch   <= pick.idx;
                        has_last  <= 1'b1;
                        rr_ptr    <= wrap_inc(pick.idx);
                    end else begin
                        rr_ptr    <= '0;
                        has_last  <= 1'b0;
                        pkt_start <= 1'b0;
                    end
                end
                ARB_BUSY: begin
                    pkt_start <= 1'b0;
                    if (pkt_done) begin
                        state_q <= ARB_IDLE;
                        grant   <= '0;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> !pkt_start);

    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !pkt_done) |=> ($stable(grant) && $stable(grant_len)));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && pkt_done) |=> (grant == '0 && !pkt_start));

    assert_start_eligible_R1: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> (($past(elig) & grant) != '0));
endmodule

// File: rtl/vc_pkt_arbiter.sv
module vc_pkt_arbiter
    import vcarb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    seq_mode,
    input  vc_mask_t                ch_en,
    input  vc_mask_t                pkt_whole,
    input  vc_mask_t                region_full,
    input  pkt_len_t [VC_COUNT-1:0] pkt_len,
    input  logic                    pkt_done,
    output vc_mask_t                grant,
    output logic                    pkt_start,
    output pkt_len_t                grant_len
);
    vc_mask_t elig;
    vc_pick_t pick;
    vc_idx_t  rr_ptr;
    logic     has_last;
    vc_idx_t  last_ch;

    vcarb_elig u_elig (
        .ch_en       (ch_en),
        .pkt_whole   (pkt_whole),
        .region_full (region_full),
        .elig        (elig)
    );

    vcarb_pick u_pick (
        .elig     (elig),
        .rr_ptr   (rr_ptr),
        .seq_mode (seq_mode),
        .has_last (has_last),
        .last_ch  (last_ch),
        .pick     (pick)
    );

    vcarb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .pick      (pick),
        .pkt_len   (pkt_len),
        .pkt_done  (pkt_done),
        .rr_ptr    (rr_ptr),
        .has_last  (has_last),
        .last_ch   (last_ch),
        .grant     (grant),
        .pkt_start (pkt_start),
        .grant_len (grant_len)
    );
endmodule

// File: tb/sim_vc_pkt_arbiter.sv
module sim_vc_pkt_arbiter;
    import vcarb_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    seq_mode = 1'b0;
    vc_mask_t                ch_en = '0;
    vc_mask_t                pkt_whole = '0;
    vc_mask_t                region_full = '0;
    pkt_len_t [VC_COUNT-1:0] pkt_len;
    logic                    pkt_done = 1'b0;
    vc_mask_t                grant;
    logic                    pkt_start;
    pkt_len_t                grant_len;

    always #10 clk = ~clk;   // 50 MHz

    vc_pkt_arbiter u0 (
        .clk(clk), .rst(rst), .seq_mode(seq_mode), .ch_en(ch_en),
        .pkt_whole(pkt_whole), .region_full(region_full), .pkt_len(pkt_len),
        .pkt_done(pkt_done), .grant(grant), .pkt_start(pkt_start),
        .grant_len(grant_len)
    );

    typedef struct { int ch; pkt_len_t len; string req; } exp_t;
    exp_t exp_q[$];

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic pkt_len_t len_of(int ch);
        return pkt_len_t'(16'h0040 + 3 * ch);
    endfunction

    // Driver side: queue the expected next grant.
    task automatic expect_grant(int ch, string req);
        exp_t e;
        e.ch = ch; e.len = len_of(ch); e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: pop and compare every grant as it starts.
    always @(negedge clk) begin
        if (!rst && pkt_start) begin
            if (exp_q.size() == 0) begin
                check(0, "R1 unexpected grant", int'(grant), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(grant == idx_to_mask(vc_idx_t'(e.ch)), e.req, int'(grant),
                      int'(idx_to_mask(vc_idx_t'(e.ch))));
                check(grant_len == e.len, "R10 length", int'(grant_len), int'(e.len));
            end
        end
    end

    // Transmitter side: wait for one grant, hold, pulse done, check release.
    task automatic serve_one();
        vc_mask_t g;
        do @(negedge clk); while (!pkt_start);
        g = grant;
        @(negedge clk);
        check(pkt_start == 1'b0 && grant == g, "R7 hold/strobe", int'(grant), int'(g));
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        check(grant == '0 && !pkt_start, "R8 release", int'(grant), 0);
    endtask

    task automatic idle_clear();
        ch_en = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < VC_COUNT; i++) pkt_len[i] = len_of(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(grant == '0 && !pkt_start, "R11 reset state", int'(grant), 0);

        // R1: disabled but ready channels stay silent.
        pkt_whole = 4'hF; region_full = 4'hF;
        repeat (5) @(negedge clk);
        check(grant == '0, "R1 disabled ignored", int'(grant), 0);
        // R2: enabled but neither flag set.
        ch_en = 4'hF; pkt_whole = '0; region_full = '0;
        repeat (5) @(negedge clk);
        check(grant == '0, "R2 not ready ignored", int'(grant), 0);

        // R3: round-robin from 0, mixed readiness sources (R2).
        pkt_whole = 4'b0101; region_full = 4'b1010;
        expect_grant(0, "R3 rr first");
        expect_grant(1, "R3 rr second (R2 full)");
        expect_grant(2, "R3 rr third");
        expect_grant(3, "R3 rr fourth");
        expect_grant(0, "R3 rr wrap");
        repeat (5) serve_one();

        // R4: skip non-eligible channels and wrap.
        idle_clear();
        ch_en = 4'b1100;
        expect_grant(2, "R4 skip to 2");
        expect_grant(3, "R4 then 3");
        expect_grant(2, "R4 wrap to 2");
        repeat (3) serve_one();
        ch_en = 4'b1010;
        expect_grant(3, "R4 from ptr 3");
        expect_grant(1, "R4 wrap to 1");
        repeat (2) serve_one();

        // R9: idle with nothing eligible resets rotation to 0.
        idle_clear();
        ch_en = 4'b1110;
        expect_grant(1, "R9 pointer back to 0");
        serve_one();

        // R5/R6: sequential mode.
        idle_clear();
        seq_mode = 1'b1;
        pkt_whole = 4'b0011; region_full = 4'b0100;
        ch_en = 4'hF;
        expect_grant(0, "R5 seq first");
        expect_grant(0, "R5 seq repeat");
        repeat (2) serve_one();
        pkt_whole[0] = 1'b0;
        expect_grant(1, "R6 seq hand-off");
        expect_grant(1, "R5 seq repeat 1");
        repeat (2) serve_one();
        pkt_whole[1] = 1'b0;
        expect_grant(2, "R6 seq to full channel");
        serve_one();
        region_full[2] = 1'b0; pkt_whole[3] = 1'b1;
        expect_grant(3, "R2 full re-evaluated, R6 move on");
        serve_one();
        ch_en = '0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all grants seen", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule